// File: doc/BRIEF.md
# PLL Standby and Clock-Switch Controller

This block governs one on-chip PLL through a single control register. Two bits of that register put the PLL in one of three power states: off, standby (running but not selected) or on (running and selected). Three divider fields sit beside those bits: a PLL multiplier, an internal-clock divider and a peripheral-clock divider. Each power transition allows only some of these fields to change in the same write. A write that breaks a rule is dropped as a whole and a sticky error flag is raised.

Some writes start an overflow counter: those that enter or leave the on state, and those that change the multiplier while the PLL stays on. The counter starts from a programmable preload and runs until it wraps. Only on that wrap does the internal clock-source select move, and the block marks it with a one-cycle pulse. The clock-output enable bit acts at once, so the external clock output always switches before the internal source. A clock-mode input decides two more things. It decides whether the external clock output may be turned off. It also decides whether a request to enter low-power standby is granted while the PLL is still powered.

The analog PLL, the clock multiplexer and the dividers themselves are outside the block. It drives only their control signals.

Top module: `pll_clk_ctrl`

## Requirements
- R1: After reset the control register reads with the multiplier, peripheral divider and internal divider at 0, the clock-output enable bit at 1, and the standby and enable bits at 0. clk_sel_o, busy_o, err_o, sw_pulse_o, sleep_ack_o and sleep_nak_o are 0, and the counter preload holds PRELOAD_RST.
- R2: Control register layout, LSB first: bit 0 enable, bit 1 standby, bit 2 clock-output enable, bits 5:3 internal divider, bits 8:6 peripheral divider, bits 11:9 multiplier. The power state is off for {standby,enable}=00, standby for 10 and on for 11. pll_en_o and pll_stby_o show the two bits. A control write with {standby,enable}=01 is ignored and sets err_o.
- R3: Between off and standby, in either direction, a control write may change the multiplier but not the internal or peripheral divider. If it changes either divider, it is ignored and sets err_o.
- R4: From standby to on, a control write may change both dividers but not the multiplier. If it changes the multiplier, it is ignored and sets err_o.
- R5: A write that leaves the on state, to standby or to off, may change all three divider fields. A direct write from off to on is also allowed and may change any field.
- R6: A write to address 1 loads the counter preload P from wr_data_i[CNT_W-1:0]. Some accepted control writes start the counter: those that enter or leave the on state, and those that change the multiplier while the PLL stays on. busy_o is then 1 for 2^CNT_W − P cycles, starting the cycle after the write. In the cycle after the last busy cycle, sw_pulse_o is 1 for one cycle and clk_sel_o takes 1 if the state is on and 0 otherwise. clk_sel_o changes at no other time.
- R7: While busy_o is 1, a control write is ignored and sets err_o. A preload write is still taken.
- R8: err_o stays 1 once set until the next reset.
- R9: A sleep_req_i pulse is answered one cycle later by exactly one of sleep_ack_o and sleep_nak_o. It is refused when clk_mode_i is 3 or higher and the power state is not off, and granted otherwise.
- R10: With clk_mode_i below 3, ckout_en_o is 1 whatever the register holds. A control write with the clock-output enable bit at 0 is ignored and sets err_o.
- R11: With clk_mode_i at 3 or higher, ckout_en_o equals the register's clock-output enable bit from the cycle after an accepted write. When the same write starts the counter, ckout_en_o changes before clk_sel_o.
- R12: A control write that keeps the power state may change any field, and rd_ctrl_o shows every accepted write from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 selects the control register, 1 the counter preload |
| wr_data_i | input | 12 | Write data |
| clk_mode_i | input | MODE_W (3) | Clock mode of the chip |
| sleep_req_i | input | 1 | Request to enter low-power standby |
| pll_en_o | output | 1 | PLL enable bit as stored |
| pll_stby_o | output | 1 | PLL standby bit as stored |
| clk_sel_o | output | 1 | Internal clock source: 1 selects the PLL |
| sw_pulse_o | output | 1 | One-cycle pulse when the counter overflows |
| busy_o | output | 1 | Counter running, control writes blocked |
| err_o | output | 1 | Sticky error for an ignored control write |
| ckout_en_o | output | 1 | External clock output enable |
| sleep_ack_o | output | 1 | Standby request granted |
| sleep_nak_o | output | 1 | Standby request refused |
| rd_ctrl_o | output | 12 | Control register contents |

## Verification
The hardest case is a write rejected because the counter is busy. It needs a counter started by a legal transition, a short preload so the busy window stays small, and a second control write placed inside that window. In the same window the stimulus sends a preload write. Its effect shows later as a one-cycle busy period on a multiplier change, which proves the write was taken while control writes were blocked. Once err_o is set it stays set, so the sequence relies on a mid-run reset to show that the error clears only through reset.

// File: rtl/pllc_pkg.sv
package pllc_pkg;

    localparam int DIV_W = 3;

    // Control register image, LSB first: en, stby, ckout, idiv, pdiv, mult
    typedef struct packed {
        logic [DIV_W-1:0] mult;
        logic [DIV_W-1:0] pdiv;
        logic [DIV_W-1:0] idiv;
        logic             ckout;
        logic             stby;
        logic             en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Power state code {stby, en}
    typedef enum logic [1:0] {
        PWR_OFF  = 2'b00,
        PWR_STBY = 2'b10,
        PWR_ON   = 2'b11
    } pwr_e;

    localparam ctrl_t CTRL_RST = '{mult: '0, pdiv: '0, idiv: '0,
                                   ckout: 1'b1, stby: 1'b0, en: 1'b0};

endpackage

// File: rtl/pllc_wr_check.sv
module pllc_wr_check
    import pllc_pkg::*;
#(
    parameter int MODE_W       = 3,
    parameter int MODE_PLL_MIN = 3
) (
    input  ctrl_t             cur_i,
    input  ctrl_t             req_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              busy_i,
    output logic              accept_o,
    output logic              start_o
);

    logic [1:0] cur_code;
    logic [1:0] req_code;
    logic       code_ok;
    logic       field_ok;
    logic       ckout_ok;
    logic       pll_mode;
    logic       cur_on;
    logic       req_on;
    logic       keep_divs;
    logic       keep_mult;

    always_comb begin
        cur_code  = {cur_i.stby, cur_i.en};
        req_code  = {req_i.stby, req_i.en};
        pll_mode  = (mode_i >= MODE_W'(MODE_PLL_MIN));
        keep_divs = (req_i.idiv == cur_i.idiv) && (req_i.pdiv == cur_i.pdiv);
        keep_mult = (req_i.mult == cur_i.mult);

        code_ok = (req_code == PWR_OFF) || (req_code == PWR_STBY) || (req_code == PWR_ON);

        field_ok = 1'b1;
        if ((cur_code == PWR_OFF && req_code == PWR_STBY) ||
            (cur_code == PWR_STBY && req_code == PWR_OFF)) begin
            field_ok = keep_divs;
        end else if (cur_code == PWR_STBY && req_code == PWR_ON) begin
            field_ok = keep_mult;
        end

        ckout_ok = pll_mode || req_i.ckout;

        accept_o = !busy_i && code_ok && field_ok && ckout_ok;

        cur_on  = (cur_code == PWR_ON);
        req_on  = (req_code == PWR_ON);
        start_o = accept_o && ((cur_on != req_on) || (cur_on && req_on && !keep_mult));
    end

endmodule

// File: rtl/pllc_ovf_cnt.sv
module pllc_ovf_cnt #(
    parameter int          CNT_W       = 8,
    parameter int unsigned PRELOAD_RST = 32'hF0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pre_we_i,
    input  logic [CNT_W-1:0] pre_i,
    input  logic             start_i,
    output logic             run_o,
    output logic             ovf_now_o,
    output logic             pulse_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] PRE_RST = CNT_W'(PRELOAD_RST);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] pre;
        logic             run;
        logic             pulse;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (pre_we_i) begin
            st_d.pre = pre_i;
        end
        if (st_q.run) begin
            if (st_q.cnt == CNT_MAX) begin
                st_d.run   = 1'b0;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (start_i) begin
            st_d.run = 1'b1;
            st_d.cnt = st_q.pre;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt   <= '0;
            st_q.pre   <= PRE_RST;
            st_q.run   <= 1'b0;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o     = st_q.run;
    assign ovf_now_o = st_q.run && (st_q.cnt == CNT_MAX);
    assign pulse_o   = st_q.pulse;

endmodule

// File: rtl/pllc_sleep_gate.sv
module pllc_sleep_gate #(
    parameter int MODE_W       = 3,
    parameter int MODE_PLL_MIN = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              pll_off_i,
    output logic              ack_o,
    output logic              nak_o
);

    typedef struct packed {
        logic ack;
        logic nak;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     refuse;

    always_comb begin
        refuse   = (mode_i >= MODE_W'(MODE_PLL_MIN)) && !pll_off_i;
        st_d.ack = req_i && !refuse;
        st_d.nak = req_i && refuse;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_o = st_q.ack;
    assign nak_o = st_q.nak;

endmodule

// File: rtl/pll_clk_ctrl.sv
module pll_clk_ctrl
    import pllc_pkg::*;
#(
    parameter int          CNT_W        = 8,
    parameter int unsigned PRELOAD_RST  = 32'hF0,
    parameter int          MODE_W       = 3,
    parameter int          MODE_PLL_MIN = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              wr_addr_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    input  logic [MODE_W-1:0] clk_mode_i,
    input  logic              sleep_req_i,
    output logic              pll_en_o,
    output logic              pll_stby_o,
    output logic              clk_sel_o,
    output logic              sw_pulse_o,
    output logic              busy_o,
    output logic              err_o,
    output logic              ckout_en_o,
    output logic              sleep_ack_o,
    output logic              sleep_nak_o,
    output logic [CTRL_W-1:0] rd_ctrl_o
);

    typedef struct packed {
        ctrl_t ctrl;
        logic  sel;
        logic  err;
    } top_st_t;

    top_st_t st_d, st_q;

    ctrl_t req;
    logic  ctrl_we;
    logic  pre_we;
    logic  wr_ok;
    logic  wr_start;
    logic  cnt_run;
    logic  ovf_now;
    logic  ovf_pulse;
    logic  pll_off;

    assign req     = ctrl_t'(wr_data_i);
    assign ctrl_we = wr_en_i && !wr_addr_i;
    assign pre_we  = wr_en_i && wr_addr_i;
    assign pll_off = !st_q.ctrl.en && !st_q.ctrl.stby;

    pllc_wr_check #(
        .MODE_W       (MODE_W),
        .MODE_PLL_MIN (MODE_PLL_MIN)
    ) i_wr_check (
        .cur_i    (st_q.ctrl),
        .req_i    (req),
        .mode_i   (clk_mode_i),
        .busy_i   (cnt_run),
        .accept_o (wr_ok),
        .start_o  (wr_start)
    );

    pllc_ovf_cnt #(
        .CNT_W       (CNT_W),
        .PRELOAD_RST (PRELOAD_RST)
    ) i_ovf_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pre_we_i  (pre_we),
        .pre_i     (wr_data_i[CNT_W-1:0]),
        .start_i   (ctrl_we && wr_start),
        .run_o     (cnt_run),
        .ovf_now_o (ovf_now),
        .pulse_o   (ovf_pulse)
    );

    pllc_sleep_gate #(
        .MODE_W       (MODE_W),
        .MODE_PLL_MIN (MODE_PLL_MIN)
    ) i_sleep_gate (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .req_i     (sleep_req_i),
        .mode_i    (clk_mode_i),
        .pll_off_i (pll_off),
        .ack_o     (sleep_ack_o),
        .nak_o     (sleep_nak_o)
    );

    always_comb begin
        st_d = st_q;
        if (ctrl_we) begin
            if (wr_ok) begin
                st_d.ctrl = req;
            end else begin
                st_d.err = 1'b1;
            end
        end
        if (ovf_now) begin
            st_d.sel = st_q.ctrl.en && st_q.ctrl.stby;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.ctrl <= CTRL_RST;
            st_q.sel  <= 1'b0;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pll_en_o   = st_q.ctrl.en;
    assign pll_stby_o = st_q.ctrl.stby;
    assign clk_sel_o  = st_q.sel;
    assign sw_pulse_o = ovf_pulse;
    assign busy_o     = cnt_run;
    assign err_o      = st_q.err;
    assign rd_ctrl_o  = st_q.ctrl;
    assign ckout_en_o = (clk_mode_i < MODE_W'(MODE_PLL_MIN)) ? 1'b1 : st_q.ctrl.ckout;

endmodule

// File: rtl/pll_clk_ctrl_chk.sv
module pll_clk_ctrl_chk
    import pllc_pkg::*;
#(
    parameter int MODE_W       = 3,
    parameter int MODE_PLL_MIN = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic              wr_addr_i,
    input logic [MODE_W-1:0] clk_mode_i,
    input logic              sleep_req_i,
    input logic              pll_en_o,
    input logic              pll_stby_o,
    input logic              clk_sel_o,
    input logic              sw_pulse_o,
    input logic              busy_o,
    input logic              err_o,
    input logic              ckout_en_o,
    input logic              sleep_ack_o,
    input logic              sleep_nak_o,
    input logic [CTRL_W-1:0] rd_ctrl_o
);

    ctrl_t cur;
    assign cur = ctrl_t'(rd_ctrl_o);

    // R2
    bad_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(pll_en_o && !pll_stby_o));

    // R3
    off_stby_divs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pll_en_o && !$stable(pll_stby_o) && !$past(pll_en_o)) |-> ($stable(cur.idiv) && $stable(cur.pdiv)));

    // R4
    stby_on_mult_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(pll_en_o) && $past(pll_stby_o)) |-> $stable(cur.mult));

    // R6
    pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sw_pulse_o |=> !sw_pulse_o);

    // R6
    busy_end_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> sw_pulse_o);

    // R6
    sel_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(clk_sel_o) |-> sw_pulse_o);

    // R7
    busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && wr_en_i && !wr_addr_i) |=> ($stable(rd_ctrl_o) && err_o));

    // R8
    err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> err_o);

    // R9
    sleep_answer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sleep_req_i |=> (sleep_ack_o != sleep_nak_o));

    // R9
    sleep_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sleep_ack_o && sleep_nak_o));

    // R10
    ckout_forced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clk_mode_i < MODE_W'(MODE_PLL_MIN)) |-> ckout_en_o);

endmodule

bind pll_clk_ctrl pll_clk_ctrl_chk #(
    .MODE_W       (MODE_W),
    .MODE_PLL_MIN (MODE_PLL_MIN)
) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .clk_mode_i  (clk_mode_i),
    .sleep_req_i (sleep_req_i),
    .pll_en_o    (pll_en_o),
    .pll_stby_o  (pll_stby_o),
    .clk_sel_o   (clk_sel_o),
    .sw_pulse_o  (sw_pulse_o),
    .busy_o      (busy_o),
    .err_o       (err_o),
    .ckout_en_o  (ckout_en_o),
    .sleep_ack_o (sleep_ack_o),
    .sleep_nak_o (sleep_nak_o),
    .rd_ctrl_o   (rd_ctrl_o)
);

// File: tb/test_pll_clk_ctrl.sv
`timescale 1ns/1ps
module test_pll_clk_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [11:0] wr_data = '0;
    logic [2:0]  clk_mode = 3'd4;
    logic        sleep_req = 1'b0;
    logic        pll_en, pll_stby, clk_sel, sw_pulse, busy, err, ckout_en, sleep_ack, sleep_nak;
    logic [11:0] rd_ctrl;

    always #2.5 clk = ~clk;

    pll_clk_ctrl i_pll_clk_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .clk_mode_i(clk_mode), .sleep_req_i(sleep_req),
        .pll_en_o(pll_en), .pll_stby_o(pll_stby), .clk_sel_o(clk_sel),
        .sw_pulse_o(sw_pulse), .busy_o(busy), .err_o(err), .ckout_en_o(ckout_en),
        .sleep_ack_o(sleep_ack), .sleep_nak_o(sleep_nak), .rd_ctrl_o(rd_ctrl)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // scoreboard queues: cycle to compare at, requirement tag, expected vector
    int          q_cyc[$];
    string       q_req[$];
    logic [20:0] q_exp[$];

    // reference model state, from the requirements
    logic [11:0] m_ctrl;
    logic        m_sel, m_err;
    int          m_left;
    logic [7:0]  m_pre;
    logic [2:0]  mode_v = 3'd4;

    task automatic model_reset();
        m_ctrl = 12'h004; m_sel = 0; m_err = 0; m_left = 0; m_pre = 8'hF0;
    endtask

    function automatic logic [11:0] mk(input int mult, input int pdiv, input int idiv,
                                       input bit ck, input bit stby, input bit en);
        return {mult[2:0], pdiv[2:0], idiv[2:0], ck, stby, en};
    endfunction

    // monitor: compares expected items against the ports
    always @(posedge clk) begin
        cyc = cyc + 1;
        #1;
        while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            logic [20:0] act;
            logic [20:0] exp;
            string       req;
            exp = q_exp.pop_front();
            req = q_req.pop_front();
            void'(q_cyc.pop_front());
            act = {rd_ctrl, pll_en, pll_stby, clk_sel, busy, err, ckout_en, sw_pulse, sleep_ack, sleep_nak};
            checks++;
            if (act !== exp) begin
                errors++;
                $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
            end
        end
    end

    // driver: applies one cycle of stimulus and pushes the expected result
    task automatic step(input bit we, input bit wa, input logic [11:0] wd,
                        input bit sreq, input string req);
        logic       was_busy, pulse, ack, nak, bad, start;
        logic [1:0] os, ns;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; sleep_req = sreq; clk_mode = mode_v;
        ack = sreq && !(mode_v >= 3 && m_ctrl[1:0] != 2'b00);
        nak = sreq && !ack;
        was_busy = (m_left > 0);
        pulse = 0;
        if (was_busy) begin
            m_left--;
            if (m_left == 0) begin
                pulse = 1;
                m_sel = (m_ctrl[1:0] == 2'b11);
            end
        end
        if (we && wa) begin
            m_pre = wd[7:0];
        end else if (we) begin
            os = m_ctrl[1:0];
            ns = wd[1:0];
            bad = was_busy || (ns == 2'b01) || (mode_v < 3 && !wd[2]);
            if ((os == 2'b00 && ns == 2'b10) || (os == 2'b10 && ns == 2'b00))
                bad = bad || (wd[8:3] != m_ctrl[8:3]);
            if (os == 2'b10 && ns == 2'b11)
                bad = bad || (wd[11:9] != m_ctrl[11:9]);
            if (bad) begin
                m_err = 1;
            end else begin
                start = ((os == 2'b11) != (ns == 2'b11)) ||
                        (os == 2'b11 && ns == 2'b11 && wd[11:9] != m_ctrl[11:9]);
                m_ctrl = wd;
                if (start) m_left = 256 - int'(m_pre);
            end
        end
        q_cyc.push_back(cyc + 1);
        q_req.push_back(req);
        q_exp.push_back({m_ctrl, m_ctrl[0], m_ctrl[1], m_sel, (m_left > 0), m_err,
                         (mode_v < 3) ? 1'b1 : m_ctrl[2], pulse, ack, nak});
        @(posedge clk);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(0, 0, '0, 0, req);
    endtask

    task automatic wr(input logic [11:0] d, input string req);
        step(1, 0, d, 0, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; wr_en = 0; sleep_req = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    initial begin
        model_reset();
        do_reset();
        idle(2, "R1 reset state");
        // off to on directly, default preload gives 16 busy cycles
        wr(mk(0,0,0,1,1,1), "R6 off to on");
        idle(18, "R6 busy window and switch");
        step(1, 1, 12'h0FC, 0, "R6 preload write");
        step(0, 0, '0, 1, "R9 refuse while on");
        idle(1, "R9");
        wr(mk(2,1,3,1,1,0), "R5 on to standby");
        idle(5, "R6 switch back");
        wr(mk(2,4,5,1,1,1), "R4 standby to on");
        wr(mk(2,4,5,1,0,0), "R7 write while busy");
        step(1, 1, 12'h0FF, 0, "R7 preload while busy");
        idle(4, "R7");
        wr(mk(6,4,5,1,1,1), "R12 mult change while on");
        idle(3, "R12");
        wr(mk(1,0,0,0,0,0), "R11 on to off with output off");
        idle(5, "R11 output before source");
        step(0, 0, '0, 1, "R9 grant while off");
        idle(1, "R9");
        do_reset();
        idle(1, "R8 error cleared by reset");
        wr(mk(3,0,0,1,1,0), "R3 off to standby");
        wr(mk(3,0,2,1,0,0), "R3 divider change rejected");
        step(0, 0, '0, 1, "R9 refuse in standby");
        wr(mk(5,0,0,1,1,1), "R4 mult change rejected");
        wr(mk(3,0,0,1,0,1), "R2 bad code rejected");
        idle(2, "R8 error sticky");
        do_reset();
        wr(mk(3,0,0,1,1,0), "R3");
        wr(mk(3,0,0,0,1,0), "R11 output enable cleared");
        idle(1, "R11");
        mode_v = 3'd1;
        idle(1, "R10 output forced on");
        step(0, 0, '0, 1, "R9 grant in low mode");
        wr(mk(3,0,0,0,1,0), "R10 clear rejected");
        wr(mk(3,2,1,1,1,0), "R12 same-state field change");
        idle(2, "R12");
        #3;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R6 watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule